// File: doc/BRIEF.md
# Programmable slot calendar sequencer

This block holds a table of slot entries. Each entry names the device that owns that slot, or carries the idle code. While the block runs, a slot pointer steps through the active part of the table, one entry per slot tick. The owner of the current slot is presented on an output, so downstream logic knows which device may use the lane in that slot. Each lane of a bus gets its own independent copy of the block.

Software loads the table through a small register-style interface. It raises a program-enable bit, then writes an index followed by a value for each slot it wants to set. When it drops the enable bit, the new calendar takes effect. The active length becomes one more than the highest index written during that session, and a readable length field reports the active length minus one. After reset the calendar holds a single idle slot. The block does not work out schedules, and it does not arbitrate or carry data.

Top module: `slot_calendar_seq`

## Requirements
- R1: After reset the calendar has one active entry holding the idle code 13. `cur_len` reads 0, `slot_pos` reads 0, `slot_owner` reads 13 and `idx_err` reads 0.
- R2: While `pgm_en` is low, `slot_owner` equals the entry at `slot_pos`. Each cycle with `slot_tick` high advances `slot_pos` by one. Without a tick, `slot_pos` holds its value.
- R3: A tick taken while `slot_pos` equals the active length minus one returns `slot_pos` to 0.
- R4: While `pgm_en` is high, `slot_owner` shows the idle code 13. During the same time `slot_pos` is forced to 0 and ticks have no effect.
- R5: With `pgm_en` high, an index write (`idx_we`, `idx_in` between 0 and 63) selects an entry. A following value write (`val_we`, 4-bit `val_in`) stores that value into the selected entry. Values 14 and 15 are stored as 13, so an entry only ever holds 0 to 12 or 13.
- R6: When `pgm_en` falls, the active length becomes one more than the largest index that received a value in the session. `cur_len` then reads that length minus one, and `slot_pos` restarts at 0. Entries not written keep their earlier contents.
- R7: A session in which no value is stored leaves the active length unchanged.
- R8: An index write with `idx_in` of 64 or more (7-bit field) changes no entry and no length. It sets `idx_err`, which stays set until reset. Value writes that follow a rejected index are dropped until an accepted index is written.
- R9: Index and value writes made while `pgm_en` is low are ignored.
- R10: `cur_len` keeps its old value for the whole session and changes only when the session ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | Advance to the next slot |
| pgm_en | input | 1 | Programming session active |
| idx_we | input | 1 | Index write strobe |
| idx_in | input | 7 | Slot index to write |
| val_we | input | 1 | Value write strobe |
| val_in | input | 4 | Slot owner value (13 = idle) |
| slot_owner | output | 4 | Owner of the current slot |
| slot_pos | output | 6 | Current slot pointer |
| cur_len | output | 6 | Active length minus one |
| idx_err | output | 1 | Sticky rejected-index flag |

## Verification
On every cycle, the checker confirms several invariants. The owner is idle and the pointer is cleared during programming. The pointer never passes the active length, and it wraps after the last active entry. Without a tick, it either holds or restarts at 0. The length readback does not move mid-session, and the error flag stays set once raised. Only the bench scenarios can show the rest: which values actually landed in which entries, how the committed length follows the highest index written, how 14 and 15 clamp to idle, that dropped and out-of-session writes leave the table untouched, and that the full 64-entry calendar wraps correctly.

// File: rtl/slot_calendar_seq.sv
module slot_calendar_seq #(
  parameter int DEPTH = 64,
  parameter int NDEV  = 13,
  localparam int IW   = $clog2(DEPTH),
  localparam int VW   = $clog2(NDEV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          pgm_en,
  input  logic          idx_we,
  input  logic [IW:0]   idx_in,
  input  logic          val_we,
  input  logic [VW-1:0] val_in,
  output logic [VW-1:0] slot_owner,
  output logic [IW-1:0] slot_pos,
  output logic [IW-1:0] cur_len,
  output logic          idx_err
);
  localparam logic [VW-1:0] IDLE_V  = VW'(NDEV);
  localparam logic [IW:0]   DEPTH_V = (IW+1)'(DEPTH);

  logic [VW-1:0] tbl [DEPTH];
  logic [IW-1:0] ptr, len_m1, wr_idx, sess_hi;
  logic          pgm_q, idx_ok, sess_any, err;

  wire           commit   = ~pgm_en & pgm_q;
  wire           idx_good = idx_in < DEPTH_V;
  wire           store    = pgm_en & val_we & idx_ok;
  wire [VW-1:0]  val_c    = (val_in > IDLE_V) ? IDLE_V : val_in;
  wire [IW-1:0]  hi_next  = (sess_any && sess_hi > wr_idx) ? sess_hi : wr_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= IDLE_V;
    end else if (store) begin
      tbl[wr_idx] <= val_c;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pgm_q    <= 1'b0;
      ptr      <= '0;
      len_m1   <= '0;
      wr_idx   <= '0;
      sess_hi  <= '0;
      idx_ok   <= 1'b0;
      sess_any <= 1'b0;
      err      <= 1'b0;
    end else begin
      pgm_q <= pgm_en;
      if (pgm_en) begin
        ptr <= '0;
        if (idx_we) begin
          if (idx_good) begin
            wr_idx <= idx_in[IW-1:0];
            idx_ok <= 1'b1;
          end else begin
            idx_ok <= 1'b0;
            err    <= 1'b1;
          end
        end
        if (store) begin
          sess_hi  <= hi_next;
          sess_any <= 1'b1;
        end
      end else if (commit) begin
        ptr      <= '0;
        sess_any <= 1'b0;
        idx_ok   <= 1'b0;
        if (sess_any) len_m1 <= sess_hi;
      end else if (slot_tick) begin
        ptr <= (ptr == len_m1) ? '0 : ptr + 1'b1;
      end
    end

  assign slot_owner = pgm_en ? IDLE_V : tbl[ptr];
  assign slot_pos   = ptr;
  assign cur_len    = len_m1;
  assign idx_err    = err;
endmodule

// File: rtl/slot_calendar_seq_chk.sv
module slot_calendar_seq_chk #(
  parameter int DEPTH = 64,
  parameter int NDEV  = 13,
  localparam int IW   = $clog2(DEPTH),
  localparam int VW   = $clog2(NDEV + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_tick,
  input logic          pgm_en,
  input logic [VW-1:0] slot_owner,
  input logic [IW-1:0] slot_pos,
  input logic [IW-1:0] cur_len,
  input logic          idx_err
);
  // R4
  owner_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |-> slot_owner == VW'(NDEV));
  // R4
  pos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> slot_pos == '0);
  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pos <= cur_len);
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_en && slot_tick && slot_pos == cur_len) |=> slot_pos == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_en && !slot_tick) |=> (slot_pos == $past(slot_pos) || slot_pos == '0));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);
  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> $stable(cur_len));
  // R5
  owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_owner <= VW'(NDEV));
endmodule

bind slot_calendar_seq slot_calendar_seq_chk #(.DEPTH(DEPTH), .NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .pgm_en(pgm_en),
  .slot_owner(slot_owner), .slot_pos(slot_pos), .cur_len(cur_len), .idx_err(idx_err)
);

// File: tb/slot_calendar_seq_test.sv
module slot_calendar_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_tick = 1'b0, pgm_en = 1'b0, idx_we = 1'b0, val_we = 1'b0;
  logic [6:0] idx_in = '0;
  logic [3:0] val_in = '0;
  logic [3:0] slot_owner;
  logic [5:0] slot_pos, cur_len;
  logic       idx_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_calendar_seq uut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .pgm_en(pgm_en),
    .idx_we(idx_we), .idx_in(idx_in), .val_we(val_we), .val_in(val_in),
    .slot_owner(slot_owner), .slot_pos(slot_pos), .cur_len(cur_len), .idx_err(idx_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
  endtask

  task automatic wr(int idx, int val);
    @(negedge clk) begin idx_we = 1'b1; idx_in = 7'(idx); end
    @(negedge clk) begin idx_we = 1'b0; val_we = 1'b1; val_in = 4'(val); end
    @(negedge clk) val_we = 1'b0;
  endtask

  task automatic sess_on();
    @(negedge clk) pgm_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic sess_off();
    @(negedge clk) pgm_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cur_len", cur_len, 0);
    chk("R1", "owner", slot_owner, 13);
    chk("R1", "pos", slot_pos, 0);
    chk("R1", "err", idx_err, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3", "single-entry pos", slot_pos, 0);
      chk("R1", "single-entry owner", slot_owner, 13);
    end
  endtask

  task automatic t_basic();
    int seq [4] = '{7, 0, 12, 3};
    sess_on();
    wr(0, 3); wr(1, 7); wr(2, 0); wr(3, 12);
    chk("R4", "owner in session", slot_owner, 13);
    chk("R10", "len in session", cur_len, 0);
    sess_off();
    chk("R6", "cur_len", cur_len, 3);
    chk("R6", "pos restart", slot_pos, 0);
    chk("R2", "owner pos0", slot_owner, 3);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2", "owner step", slot_owner, seq[i]);
      chk("R3", "pos step", slot_pos, (i + 1) % 4);
    end
    repeat (3) @(negedge clk);
    chk("R2", "hold pos", slot_pos, 0);
    chk("R2", "hold owner", slot_owner, 3);
  endtask

  task automatic t_sparse();
    int seq [6] = '{7, 0, 12, 13, 2, 3};
    tick(); tick();
    chk("R2", "pos before session", slot_pos, 2);
    sess_on();
    chk("R4", "pos cleared", slot_pos, 0);
    tick();
    chk("R4", "tick ignored", slot_pos, 0);
    wr(5, 2);
    wr(4, 15);
    chk("R10", "len in session", cur_len, 3);
    sess_off();
    chk("R6", "sparse cur_len", cur_len, 5);
    chk("R6", "kept entry0", slot_owner, 3);
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(i == 3 ? "R5" : "R6", "sparse owner", slot_owner, seq[i]);
    end
    chk("R3", "sparse wrap", slot_pos, 0);
  endtask

  task automatic t_off_write();
    wr(1, 9);
    chk("R9", "cur_len", cur_len, 5);
    chk("R9", "owner pos0", slot_owner, 3);
    tick();
    chk("R9", "entry1 kept", slot_owner, 7);
    chk("R9", "err", idx_err, 0);
    for (int i = 0; i < 5; i++) tick();
    chk("R3", "back at 0", slot_pos, 0);
  endtask

  task automatic t_bad_index();
    sess_on();
    wr(64, 1);
    chk("R8", "err set", idx_err, 1);
    wr(100, 1);
    sess_off();
    chk("R8", "len kept", cur_len, 5);
    chk("R8", "entry0 kept", slot_owner, 3);
    for (int i = 0; i < 4; i++) tick();
    chk("R8", "entry4 kept", slot_owner, 13);
    tick(); tick();
    chk("R8", "err sticky", idx_err, 1);
  endtask

  task automatic t_empty();
    sess_on();
    sess_off();
    chk("R7", "len kept", cur_len, 5);
    chk("R7", "pos", slot_pos, 0);
  endtask

  task automatic t_full();
    sess_on();
    wr(63, 9);
    sess_off();
    chk("R6", "full cur_len", cur_len, 63);
    for (int i = 0; i < 63; i++) tick();
    chk("R2", "pos 63", slot_pos, 63);
    chk("R5", "entry63", slot_owner, 9);
    tick();
    chk("R3", "full wrap", slot_pos, 0);
    chk("R3", "full wrap owner", slot_owner, 3);
    chk("R8", "err still set", idx_err, 1);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R1", "err cleared", idx_err, 0);
    chk("R1", "len cleared", cur_len, 0);
    chk("R1", "owner idle", slot_owner, 13);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_sparse();
    t_off_write();
    t_bad_index();
    t_empty();
    t_full();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule